// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a four-bit counter made of two sections that can be chained in different ways. The low bit is a divide-by-two section. The upper three bits form a divide-by-five section. Each section moves one step when a falling edge appears on the count input that feeds it. Falling edges are found by comparing each count input with its value one system clock earlier, so all state changes happen on the rising edge of the single system clock.

A mode value sets how the sections are chained:
- **Decade mode:** count pulses enter on input A and the output follows binary-coded decimal.
- **Bi-quinary mode:** count pulses enter on input B and the low bit becomes a square wave at one tenth of the pulse rate, with equal high and low times.
- **Split mode:** the two sections run on their own inputs.

The mode is taken in only during reset or while the counter is held in clear. Clearing and presetting to nine are gated: each takes effect only when both of its two inputs are high. This suits nine's-complement use of the decimal code.

Top module: `dqc_counter`

## Requirements
- R1: While `rst` is high, `q` becomes 0 at the next clock edge and the mode register takes the value of `mode`.
- R2: When `clr_a` and `clr_b` are both high and the preset pair is not both high, `q` is 0 after the next clock edge.
- R3: When `nine_a` and `nine_b` are both high, `q` is 4'b1001 after the next clock edge. This holds even if both clear inputs are also high, so preset wins over clear.
- R4: One clear input high alone, or one preset input high alone, leaves `q` unchanged.
- R5: A section moves only when its count input was 1 at one clock edge and 0 at the next. A rising edge, or an input held at one level, does not move it.
- R6: In decade mode (`mode`=2'b00), each falling edge on `cnt_a` steps `q` through 0,1,...,9 and then back to 0. The upper section moves when `q[0]` goes from 1 to 0. `cnt_b` is ignored.
- R7: In bi-quinary mode (`mode`=2'b01), each falling edge on `cnt_b` steps `q[3:1]`. `q[0]` toggles when `q[3:1]` wraps from 3'b100 to 0, so `q[0]` is high for 5 of every 10 input edges. `cnt_a` is ignored.
- R8: In split mode (`mode`=2'b10 or 2'b11), `q[0]` toggles on each falling edge of `cnt_a` and `q[3:1]` steps on each falling edge of `cnt_b`. Neither section affects the other.
- R9: The upper section `q[3:1]` counts 000, 001, 010, 011, 100 and then returns to 000. It never holds a value above 100.
- R10: A change on `mode` has no effect unless `rst` is high or both clear inputs are high.
- R11: A clear or a preset in the same cycle as a count edge overrides that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-five section |
| clr_a | input | 1 | Clear gate input, first half |
| clr_b | input | 1 | Clear gate input, second half |
| nine_a | input | 1 | Preset-to-nine gate input, first half |
| nine_b | input | 1 | Preset-to-nine gate input, second half |
| mode | input | 2 | Chaining: 00 decade, 01 bi-quinary, 10/11 split |
| q | output | 4 | Count: q[0] divide-by-two bit, q[3:1] divide-by-five bits |

## Verification
Two pairs of events can fall in the same cycle:
- **Count edge with a load.** The bench moves the counter to a non-zero value, drops `cnt_a` to 0 in the same cycle that both clear inputs go high, and expects 0 rather than the next count.
- **Clear with preset.** The bench raises both clear inputs and both preset inputs together and expects nine.

Each case is judged on `q` one clock after the stimulus. A single gate input raised alone is judged the same way: `q` must keep its previous value.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

    typedef enum logic [1:0] {
        MODE_BCD   = 2'd0,
        MODE_BIQ   = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_ALT   = 2'd3
    } mode_e;

    localparam int FIVE_W = 3;
    localparam logic [FIVE_W-1:0] FIVE_LAST = 3'd4;

    typedef struct packed {
        logic [FIVE_W-1:0] five;
        logic              two;
    } cnt_t;

    localparam cnt_t CNT_NINE = '{five: FIVE_LAST, two: 1'b1};

    function automatic logic [FIVE_W-1:0] five_next(logic [FIVE_W-1:0] s);
        return (s >= FIVE_LAST) ? '0 : s + 1'b1;
    endfunction

endpackage

// File: rtl/dqc_fall.sv
module dqc_fall #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= sig[i];
        end
        assign fall[i] = prev[i] & ~sig[i];
    end

    // R5: a fall is reported only when the input was high one clock earlier
    p_fall_needs_high_r5: assert property (@(posedge clk) disable iff (rst)
        fall[0] |-> $past(sig[0]));
endmodule

// File: rtl/dqc_div2.sv
module dqc_div2 (
    input  logic clk,
    input  logic rst,
    input  logic load_zero,
    input  logic load_one,
    input  logic tick,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (load_one)  q <= 1'b1;
        else if (load_zero) q <= 1'b0;
        else if (tick)      q <= ~q;
    end

    // R8: an unloaded tick always flips the bit
    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_zero && !load_one) |=> (q != $past(q)));
endmodule

// File: rtl/dqc_div5.sv
module dqc_div5
    import dqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_zero,
    input  logic              load_last,
    input  logic              tick,
    output logic [FIVE_W-1:0] s
);
    always_ff @(posedge clk) begin
        if (rst)            s <= '0;
        else if (load_last) s <= FIVE_LAST;
        else if (load_zero) s <= '0;
        else if (tick)      s <= five_next(s);
    end

    // R9: the section never leaves its five legal states
    p_five_legal_r9: assert property (@(posedge clk) disable iff (rst)
        s <= FIVE_LAST);

    // R9: the last state returns to zero on a step
    p_five_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_zero && !load_last && s == FIVE_LAST) |=> (s == '0));
endmodule

// File: rtl/dqc_counter.sv
module dqc_counter
    import dqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_a,
    input  logic       cnt_b,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       nine_a,
    input  logic       nine_b,
    input  logic [1:0] mode,
    output logic [3:0] q
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] fall;
    logic            clr_g, nine_g, zero_ld;
    logic            tick_two, tick_five;
    logic            carry_two, carry_five;
    mode_e           mode_r;
    cnt_t            cnt;

    assign clr_g   = clr_a & clr_b;
    assign nine_g  = nine_a & nine_b;
    assign zero_ld = clr_g & ~nine_g;

    always_ff @(posedge clk) begin
        if (rst || clr_g) mode_r <= mode_e'(mode);
    end

    dqc_fall #(.N(N_IN)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .sig  ({cnt_b, cnt_a}),
        .fall (fall)
    );

    // carries are taken from the raw edges so the two sections form no loop
    assign carry_two  = fall[0] & cnt.two;
    assign carry_five = fall[1] & cnt.five[FIVE_W-1];

    always_comb begin
        unique case (mode_r)
            MODE_BCD: begin
                tick_two  = fall[0];
                tick_five = carry_two;
            end
            MODE_BIQ: begin
                tick_five = fall[1];
                tick_two  = carry_five;
            end
            default: begin
                tick_two  = fall[0];
                tick_five = fall[1];
            end
        endcase
    end

    dqc_div2 u_two (
        .clk       (clk),
        .rst       (rst),
        .load_zero (zero_ld),
        .load_one  (nine_g),
        .tick      (tick_two),
        .q         (cnt.two)
    );

    dqc_div5 u_five (
        .clk       (clk),
        .rst       (rst),
        .load_zero (zero_ld),
        .load_last (nine_g),
        .tick      (tick_five),
        .s         (cnt.five)
    );

    assign q = cnt;

    // R1: reset returns the count to zero
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (q == 4'd0));

    // R2: the full clear gate zeroes the count
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_g && !nine_g) |=> (q == 4'd0));

    // R3: the full preset gate loads nine, ahead of clear
    p_nine_r3: assert property (@(posedge clk) disable iff (rst)
        nine_g |=> (q == 4'b1001));

    // R4 R5: with no full gate and no fall, the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr_g && !nine_g && fall == '0) |=> $stable(q));

    // R6: decade mode wraps from nine to zero
    p_bcd_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_r == MODE_BCD && !clr_g && !nine_g && fall[0] && q == 4'd9)
        |=> (q == 4'd0));

    // R7: bi-quinary wrap of the upper section flips the low bit
    p_biq_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_r == MODE_BIQ && !clr_g && !nine_g && fall[1] && q[3])
        |=> (q[3:1] == 3'd0 && q[0] != $past(q[0])));

    // R10: the mode register only moves during clear
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !clr_g |=> $stable(mode_r));
endmodule

// File: tb/sim_dqc_counter.sv
module sim_dqc_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_a = 1'b0, cnt_b = 1'b0;
    logic       clr_a = 1'b0, clr_b = 1'b0;
    logic       nine_a = 1'b0, nine_b = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [3:0] q;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dqc_counter u0 (
        .clk(clk), .rst(rst), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
        .mode(mode), .q(q)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [3:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic pulse_a();
        cnt_a = 1'b1; step();
        cnt_a = 1'b0; step();
    endtask

    task automatic pulse_b();
        cnt_b = 1'b1; step();
        cnt_b = 1'b0; step();
    endtask

    task automatic enter_mode(logic [1:0] m);
        mode = m; clr_a = 1'b1; clr_b = 1'b1; step();
        clr_a = 1'b0; clr_b = 1'b0; step();
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step();
        check("R1 reset", 4'd0);
        rst = 1'b0; step();
        check("R1 after reset", 4'd0);
    endtask

    task automatic t_bcd();
        enter_mode(2'b00);
        check("R2 clear", 4'd0);
        for (int i = 1; i <= 12; i++) begin
            pulse_a();
            check("R6 decade step", 4'(i % 10));
        end
        pulse_b();
        check("R6 cnt_b ignored in decade", 4'd2);
    endtask

    task automatic t_edge();
        enter_mode(2'b00);
        cnt_a = 1'b1; step(); step();
        check("R5 rising edge no step", 4'd0);
        step(); step();
        check("R5 held high no step", 4'd0);
        cnt_a = 1'b0; step();
        check("R5 falling edge steps", 4'd1);
        step(); step();
        check("R5 held low no step", 4'd1);
    endtask

    task automatic t_lone();
        enter_mode(2'b00);
        pulse_a(); pulse_a(); pulse_a();
        clr_a = 1'b1; step(); clr_a = 1'b0; step();
        check("R4 lone clr_a", 4'd3);
        clr_b = 1'b1; step(); clr_b = 1'b0; step();
        check("R4 lone clr_b", 4'd3);
        nine_a = 1'b1; step(); nine_a = 1'b0; step();
        check("R4 lone nine_a", 4'd3);
        nine_b = 1'b1; step(); nine_b = 1'b0; step();
        check("R4 lone nine_b", 4'd3);
    endtask

    task automatic t_nine();
        enter_mode(2'b00);
        nine_a = 1'b1; nine_b = 1'b1; step();
        nine_a = 1'b0; nine_b = 1'b0;
        check("R3 preset nine", 4'd9);
        pulse_a();
        check("R6 nine wraps to zero", 4'd0);
        pulse_a(); pulse_a();
        nine_a = 1'b1; nine_b = 1'b1; clr_a = 1'b1; clr_b = 1'b1; step();
        nine_a = 1'b0; nine_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        check("R3 preset beats clear", 4'd9);
    endtask

    task automatic t_override();
        enter_mode(2'b00);
        for (int i = 0; i < 5; i++) pulse_a();
        check("R6 at five", 4'd5);
        cnt_a = 1'b1; step();
        cnt_a = 1'b0; clr_a = 1'b1; clr_b = 1'b1; step();
        clr_a = 1'b0; clr_b = 1'b0;
        check("R11 clear beats edge", 4'd0);
        cnt_a = 1'b1; step();
        cnt_a = 1'b0; nine_a = 1'b1; nine_b = 1'b1; step();
        nine_a = 1'b0; nine_b = 1'b0;
        check("R11 preset beats edge", 4'd9);
    endtask

    task automatic t_mode_hold();
        enter_mode(2'b00);
        mode = 2'b01; step();
        pulse_a();
        check("R10 mode change ignored, A counts", 4'd1);
        pulse_b();
        check("R10 mode change ignored, B idle", 4'd1);
    endtask

    task automatic t_biq();
        int highs = 0;
        enter_mode(2'b01);
        for (int i = 1; i <= 20; i++) begin
            pulse_b();
            check("R7 bi-quinary step",
                  {3'(i % 5), 1'((i / 5) % 2)});
            if (q[0]) highs++;
        end
        checks++;
        if (highs != 10) begin
            errors++;
            $display("FAIL R7 duty: high=%0d expected 10", highs);
        end
        pulse_a();
        check("R7 cnt_a ignored in bi-quinary", 4'd0);
    endtask

    task automatic t_split();
        enter_mode(2'b10);
        pulse_a();
        check("R8 split A toggles", 4'b0001);
        for (int i = 1; i <= 6; i++) begin
            pulse_b();
            check("R9 upper sequence", {3'(i % 5), 1'b1});
        end
        pulse_a();
        check("R8 split A independent", {3'd1, 1'b0});
        pulse_a();
        check("R8 no carry in split", {3'd1, 1'b1});
    endtask

    initial begin
        step();
        t_reset();
        t_bcd();
        t_edge();
        t_lone();
        t_nine();
        t_override();
        t_mode_hold();
        t_biq();
        t_split();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule